// File: doc/BRIEF.md
# Reset and Boot Strap Controller

This block is board-control logic that sits between two debounced push buttons, a processor and an Ethernet PHY. Releasing the full-reset button produces a timed reset pulse on the processor's active-low full-reset output and on the PHY reset. Releasing the warm-reset button produces a timed pulse on the processor's active-low warm-reset output only. The power-on-reset output is held low only while the block's own reset is applied. A reset pulse lasts a parameterised number of clock cycles. Any button event that arrives while a pulse is running is dropped. Both button inputs pass through a two-flop synchroniser before their rising edges are detected.

While the processor's reset-status input is low, the block drives a 13-bit boot strap value onto the boot-mode pins and raises the output enable. While that input is high, the enable is low and the pins are released. A static override input replaces the DIP switch value with a fixed serial-EEPROM boot code. The override is skipped when the DIP switches select emulation boot, and the raw switch value is driven instead. Boot code can always fetch the true switch setting through a small register read port. That port has a plain read strobe and a registered response marked by a one-cycle valid. It has no back-pressure: every strobe is answered on the next cycle.

Top module: `rst_boot_ctrl`

## Requirements
- R1: While rst_n is low, por_n_o is low and full_rst_n_o, warm_rst_n_o and phy_rst_n_o are high. por_n_o is high from the first rising clock edge after rst_n goes high.
- R2: A low-to-high transition of btn_full_n_i makes full_rst_n_o and phy_rst_n_o go low from the third rising edge after the change. During that pulse warm_rst_n_o and por_n_o stay high.
- R3: A low-to-high transition of btn_warm_n_i makes warm_rst_n_o go low from the third rising edge after the change. During that pulse full_rst_n_o, phy_rst_n_o and por_n_o stay high.
- R4: Each reset pulse lasts exactly PULSE_LEN clock cycles and then releases.
- R5: A button release that arrives while a pulse is active is ignored. It neither lengthens the pulse nor changes its kind, and it is not queued for later.
- R6: When both buttons are released in the same cycle, only the full reset pulse (R2) is produced.
- R7: A high-to-low transition (button press) of either button input produces no reset pulse.
- R8: strap_oe_o equals the inverse of rstat_n_i. While rstat_n_i is high, strap_o is all zeros.
- R9: With ovr_en_i low and rstat_n_i low, strap_o equals dip_i.
- R10: With ovr_en_i high and rstat_n_i low, strap_o equals 13'h0405, unless the emulation pattern of R11 is present.
- R11: The emulation pattern is dip_i[2:0] == 3'b000 and dip_i[5:4] == 2'b00. When it is present, strap_o equals dip_i even with ovr_en_i high.
- R12: A read strobe rd_i answers on the next rising edge: rvalid_o is high for one cycle with rdata_o. Address 0 gives the DIP value and address 1 gives the strap value that R9 to R11 select, both zero-extended to 16 bits and captured one edge earlier. Addresses 2 and 3 give zero. rvalid_o is low when no read was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| btn_full_n_i | input | 1 | Debounced full-reset button, low while pressed |
| btn_warm_n_i | input | 1 | Debounced warm-reset button, low while pressed |
| ovr_en_i | input | 1 | Static enable of the forced EEPROM boot code |
| dip_i | input | 13 | Boot DIP switch value |
| rstat_n_i | input | 1 | Processor reset-status, low while the processor samples straps |
| strap_o | output | 13 | Boot-mode strap value |
| strap_oe_o | output | 1 | Output enable for the strap pins |
| por_n_o | output | 1 | Processor power-on reset, active low |
| full_rst_n_o | output | 1 | Processor full reset, active low |
| warm_rst_n_o | output | 1 | Processor warm reset, active low |
| phy_rst_n_o | output | 1 | Ethernet PHY reset, active low |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register read address |
| rdata_o | output | 16 | Register read data |
| rvalid_o | output | 1 | Read data valid, one cycle |

## Verification
Each result is due a different number of cycles after its stimulus. A reset pulse starts three rising edges after the button input changes: two synchroniser stages and the pulse register. It then stays for PULSE_LEN edges. The strap outputs follow their inputs within the same cycle. Read data is due one edge after the strobe, and it reflects switch values captured one edge before that. The bench changes inputs on falling edges, counts rising edges to the exact cycle of each change, and samples on the following falling edge. It checks the outputs on the last cycle before each change and on the first cycle after it.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  // Kind of reset pulse currently being produced
  typedef enum logic {
    RK_WARM = 1'b0,
    RK_FULL = 1'b1
  } rst_kind_e;

  // Register map of the read port
  localparam logic [1:0] REG_DIP   = 2'd0;
  localparam logic [1:0] REG_STRAP = 2'd1;

endpackage

// File: rtl/rbc_sync.sv
// Multi-bit level synchroniser, one chain of flops per bit.
module rbc_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rbc_rst_pulse.sv
// Rising-edge detection on the synchronised buttons, arbitration and
// the timed reset pulse.
module rbc_rst_pulse
  import rbc_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      full_lvl_i,
  input  logic      warm_lvl_i,
  output logic      active_o,
  output rst_kind_e kind_o
);

  localparam int            CW   = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN - 1);

  logic          full_prev_q, warm_prev_q;
  logic          full_rise, warm_rise;
  logic          active_q;
  rst_kind_e     kind_q;
  logic [CW-1:0] cnt_q;

  // A release is a low-to-high step of the synchronised level
  assign full_rise = full_lvl_i & ~full_prev_q;
  assign warm_rise = warm_lvl_i & ~warm_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_prev_q <= 1'b1;
      warm_prev_q <= 1'b1;
    end else begin
      full_prev_q <= full_lvl_i;
      warm_prev_q <= warm_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= RK_WARM;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (full_rise) begin
        active_q <= 1'b1;
        kind_q   <= RK_FULL;
        cnt_q    <= LOAD;
      end else if (warm_rise) begin
        active_q <= 1'b1;
        kind_q   <= RK_WARM;
        cnt_q    <= LOAD;
      end
    end else if (cnt_q == '0) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;

  // R2 / R6: an idle block answers a full release with a full pulse
  p_full_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && full_rise) |=> (active_q && kind_q == RK_FULL));

  // R3: a lone warm release starts a warm pulse
  p_warm_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && warm_rise && !full_rise) |=> (active_q && kind_q == RK_WARM));

  // R5: a running pulse keeps its kind regardless of new releases
  p_kind_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |=> (active_q && $stable(kind_q)));

  // R4: the pulse ends exactly when the count is spent
  p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == '0) |=> !active_q);

  // R7: without a release nothing starts
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !full_rise && !warm_rise) |=> !active_q);

endmodule

// File: rtl/rbc_strap_mux.sv
// Boot strap selection and pin enable.
module rbc_strap_mux #(
  parameter int                   STRAP_W  = 13,
  parameter logic [STRAP_W-1:0]   OVR_CODE = 13'h0405
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] dip_i,
  input  logic               ovr_en_i,
  input  logic               rstat_n_i,
  output logic [STRAP_W-1:0] sel_o,
  output logic [STRAP_W-1:0] strap_o,
  output logic               oe_o
);

  logic emu_sel;

  // Emulation boot pattern: low mode bits and bits 5:4 all zero
  assign emu_sel = (dip_i[2:0] == 3'b000) && (dip_i[5:4] == 2'b00);

  always_comb begin
    if (ovr_en_i && !emu_sel) sel_o = OVR_CODE;
    else                      sel_o = dip_i;
  end

  assign oe_o    = ~rstat_n_i;
  assign strap_o = oe_o ? sel_o : '0;

  // R8: released pins carry no value
  p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rstat_n_i |-> (!oe_o && strap_o == '0));

  // R9: without override the switches go straight out
  p_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rstat_n_i && !ovr_en_i) |-> (strap_o == dip_i));

  // R11: emulation pattern bypasses the override
  p_emu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rstat_n_i && dip_i[2:0] == 3'b000 && dip_i[5:4] == 2'b00) |-> (strap_o == dip_i));

endmodule

// File: rtl/rbc_regport.sv
// Read-only register port holding the true switch value.
module rbc_regport
  import rbc_pkg::*;
#(
  parameter int STRAP_W = 13,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] dip_i,
  input  logic [STRAP_W-1:0] sel_i,
  input  logic               rd_i,
  input  logic [1:0]         addr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);

  logic [STRAP_W-1:0] dip_q, sel_q;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dip_q <= '0;
      sel_q <= '0;
    end else begin
      dip_q <= dip_i;
      sel_q <= sel_i;
    end
  end

  always_comb begin
    case (addr_i)
      REG_DIP:   rdata_d = DATA_W'(dip_q);
      REG_STRAP: rdata_d = DATA_W'(sel_q);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R12: every strobe is answered on the next edge, nothing else is
  p_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
  p_no_extra_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rvalid_o);

endmodule

// File: rtl/rst_boot_ctrl.sv
module rst_boot_ctrl
  import rbc_pkg::*;
#(
  parameter int                 STRAP_W   = 13,
  parameter int                 DATA_W    = 16,
  parameter int                 PULSE_LEN = 16,
  parameter int                 SYNC_STG  = 2,
  parameter logic [STRAP_W-1:0] OVR_CODE  = 13'h0405
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_full_n_i,
  input  logic               btn_warm_n_i,
  input  logic               ovr_en_i,
  input  logic [STRAP_W-1:0] dip_i,
  input  logic               rstat_n_i,
  output logic [STRAP_W-1:0] strap_o,
  output logic               strap_oe_o,
  output logic               por_n_o,
  output logic               full_rst_n_o,
  output logic               warm_rst_n_o,
  output logic               phy_rst_n_o,
  input  logic               rd_i,
  input  logic [1:0]         addr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);

  logic [1:0]         btn_sync;
  logic               pulse_active;
  rst_kind_e          pulse_kind;
  logic [STRAP_W-1:0] strap_sel;
  logic               por_q;

  rbc_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({btn_full_n_i, btn_warm_n_i}),
    .q_o   (btn_sync)
  );

  rbc_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_lvl_i (btn_sync[1]),
    .warm_lvl_i (btn_sync[0]),
    .active_o   (pulse_active),
    .kind_o     (pulse_kind)
  );

  rbc_strap_mux #(.STRAP_W(STRAP_W), .OVR_CODE(OVR_CODE)) u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .dip_i     (dip_i),
    .ovr_en_i  (ovr_en_i),
    .rstat_n_i (rstat_n_i),
    .sel_o     (strap_sel),
    .strap_o   (strap_o),
    .oe_o      (strap_oe_o)
  );

  rbc_regport #(.STRAP_W(STRAP_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .dip_i    (dip_i),
    .sel_i    (strap_sel),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // Power-on reset follows the block reset, released on the first edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= 1'b0;
    else        por_q <= 1'b1;
  end

  assign por_n_o      = por_q;
  assign full_rst_n_o = ~(pulse_active && pulse_kind == RK_FULL);
  assign phy_rst_n_o  = ~(pulse_active && pulse_kind == RK_FULL);
  assign warm_rst_n_o = ~(pulse_active && pulse_kind == RK_WARM);

  // R1: power-on reset is released one edge after the block reset
  p_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> por_n_o);

  // R2: a full reset pulls the PHY along and leaves the others high
  p_full_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !full_rst_n_o |-> (!phy_rst_n_o && warm_rst_n_o));

  // R3: a warm reset touches nothing else
  p_warm_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst_n_o |-> (full_rst_n_o && phy_rst_n_o));

endmodule

// File: tb/rst_boot_ctrl_bench.sv
`timescale 1ns/1ps
module rst_boot_ctrl_bench;

  localparam int L = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        btn_full_n, btn_warm_n, ovr_en, rstat_n, rd;
  logic [12:0] dip;
  logic [1:0]  addr;
  logic [12:0] strap;
  logic        strap_oe, por_n, full_n, warm_n, phy_n, rvalid;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rst_boot_ctrl #(.PULSE_LEN(L)) u_rst_boot_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_full_n_i(btn_full_n), .btn_warm_n_i(btn_warm_n),
    .ovr_en_i(ovr_en), .dip_i(dip), .rstat_n_i(rstat_n), .strap_o(strap),
    .strap_oe_o(strap_oe), .por_n_o(por_n), .full_rst_n_o(full_n),
    .warm_rst_n_o(warm_n), .phy_rst_n_o(phy_n), .rd_i(rd), .addr_i(addr),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {por, full, warm, phy}
  function automatic logic [3:0] rst_vec();
    return {por_n, full_n, warm_n, phy_n};
  endfunction

  function automatic logic [12:0] exp_sel(input logic [12:0] d, input logic ov);
    logic emu;
    emu = (d[2:0] == 3'b000) && (d[5:4] == 2'b00);
    return (ov && !emu) ? 13'h0405 : d;
  endfunction

  // Release button(s) at a falling edge; pulse expected from the 3rd rising edge
  task automatic release_and_check(input string req, input logic f, input logic w,
                                   input logic [3:0] pulse_vec);
    @(negedge clk);
    if (f) btn_full_n = 1'b1;
    if (w) btn_warm_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({req, " before pulse"}, rst_vec(), 4'b1111);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      chk({req, " R4 pulse cycle"}, rst_vec(), pulse_vec);
    end
    @(negedge clk);
    chk({req, " R4 release"}, rst_vec(), 4'b1111);
  endtask

  task automatic press(input logic f, input logic w);
    @(negedge clk);
    if (f) btn_full_n = 1'b0;
    if (w) btn_warm_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 press no pulse", rst_vec(), 4'b1111);
  endtask

  task automatic do_read(input logic [1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    chk({req, " rvalid"}, 32'(rvalid), 32'd1);
    chk({req, " rdata"}, 32'(rdata), 32'(exp));
    @(negedge clk);
    chk("R12 rvalid idle", 32'(rvalid), 32'd0);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; btn_full_n = 1'b1; btn_warm_n = 1'b1; ovr_en = 1'b0;
    rstat_n = 1'b1; rd = 1'b0; addr = 2'd0; dip = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", rst_vec(), 4'b0111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", rst_vec(), 4'b1111);
    chk("R12 idle after reset", 32'(rvalid), 32'd0);

    // R7 then R2: press gives nothing, release gives full+PHY pulse
    press(1'b1, 1'b0);
    release_and_check("R2 full", 1'b1, 1'b0, 4'b1010);

    // R3: warm pulse only
    press(1'b0, 1'b1);
    release_and_check("R3 warm", 1'b0, 1'b1, 4'b1101);

    // R6: simultaneous releases give only the full pulse
    press(1'b1, 1'b1);
    release_and_check("R6 both", 1'b1, 1'b1, 4'b1010);

    // R5: warm release during a full pulse is ignored and not queued
    press(1'b1, 1'b1);
    @(negedge clk); btn_full_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 full pulse running", rst_vec(), 4'b1010);
    btn_warm_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 kind unchanged", rst_vec(), 4'b1010);
    repeat (L) @(negedge clk);
    chk("R5 no extension", rst_vec(), 4'b1111);
    repeat (L) @(negedge clk);
    chk("R5 not queued", rst_vec(), 4'b1111);

    // R5: full release during a warm pulse is ignored
    press(1'b1, 1'b1);
    @(negedge clk); btn_warm_n = 1'b1;
    repeat (4) @(negedge clk);
    btn_full_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 warm kind kept", rst_vec(), 4'b1101);
    repeat (L + 4) @(negedge clk);
    chk("R5 full not queued", rst_vec(), 4'b1111);

    // R8..R11: exhaustive strap sweep
    for (int d = 0; d < 8192; d++) begin
      for (int ov = 0; ov < 2; ov++) begin
        for (int rs = 0; rs < 2; rs++) begin
          logic [12:0] e;
          dip = 13'(d); ovr_en = ov[0]; rstat_n = rs[0];
          #0.2;
          e = exp_sel(13'(d), ov[0]);
          if (rs != 0) begin
            chk("R8 oe", 32'(strap_oe), 32'd0);
            chk("R8 strap released", 32'(strap), 32'd0);
          end else begin
            chk("R8 oe", 32'(strap_oe), 32'd1);
            if (ov == 0)            chk("R9 strap plain", 32'(strap), 32'(d));
            else if (e == 13'(d))   chk("R11 strap emu", 32'(strap), 32'(d));
            else                    chk("R10 strap forced", 32'(strap), 32'h0405);
          end
        end
      end
    end
    rstat_n = 1'b1;

    // R12: readback of the true switch value and of the selected strap
    for (int d = 0; d < 8192; d += 5) begin
      @(negedge clk);
      dip = 13'(d); ovr_en = 1'b1;
      do_read(2'd0, 16'(d), "R12 dip");
    end
    for (int d = 0; d < 256; d++) begin
      @(negedge clk);
      dip = 13'(d); ovr_en = d[7];
      do_read(2'd1, 16'(exp_sel(13'(d), d[7])), "R12 strap");
    end
    do_read(2'd2, 16'd0, "R12 addr2");
    do_read(2'd3, 16'd0, "R12 addr3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule